// File: doc/BRIEF.md
# Channel Self-Refresh Entry Controller

This block decides, for a single memory channel, when the DRAM behind it is put into self-refresh. Entry comes from one of two sources. A power-control agent can ask for it directly. The block can also decide on its own, using an idle counter that runs only while the memory controller has no outstanding work and no new access arrives.

Before the entry command is issued, the block asks the channel sequencer to precharge all banks and to drop CKE on every rank. It waits for a one-cycle completion pulse, and only then emits the entry strobe. While the channel is in self-refresh, the block reports that state and signals that the controller core may be powered off.

A wake request or a new access takes the channel out of self-refresh. Both flags drop in the same cycle, and the idle count starts over from zero. Each channel has its own instance.

Top module: `sr_entry_ctrl`

## Requirements
- R1: While rst is high and in the first cycle after it, prech_req_o, sr_cmd_o, sr_active_o and core_off_ok_o are all 0.
- R2: A cycle with access_i=1 clears the idle count, so the automatic count starts again from the next cycle.
- R3: The idle count is held at zero while drained_i=0. Counting begins in the first cycle with drained_i=1 and access_i=0 while the block is idle.
- R4: With auto_en_i=1 and pkg_active_i=1, prech_req_o rises after the clock edge that ends the (idle_limit_i+1)-th consecutive idle cycle. With idle_limit_i=0, this is the first idle cycle.
- R5: With auto_en_i=0, the idle counter never starts an entry.
- R6: With pkg_active_i=0, the idle counter never starts an entry.
- R7: When the block is idle, a cycle with ext_req_i=1 starts an entry, whatever the values of auto_en_i, pkg_active_i and the idle count.
- R8: prech_req_o stays high until a cycle in which prech_done_i=1. In the next cycle sr_cmd_o is 1 for exactly one cycle, and this is the only way sr_cmd_o can be asserted.
- R9: From the cycle after sr_cmd_o, sr_active_o and core_off_ok_o are both 1 and stay 1 until the channel is woken.
- R10: In self-refresh, a cycle with wake_i=1 or access_i=1 forces sr_active_o and core_off_ok_o to 0 in that same cycle. The block then returns to idle with the idle count at zero, so the next automatic entry is counted from the cycle after the wake.
- R11: At most one of prech_req_o, sr_cmd_o and sr_active_o is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| access_i | input | 1 | Access-activity strobe |
| drained_i | input | 1 | 1 when the controller has no outstanding work |
| auto_en_i | input | 1 | Enables automatic entry from the idle counter |
| idle_limit_i | input | CNT_W | Idle-count threshold |
| ext_req_i | input | 1 | Self-refresh request from the power-control agent |
| pkg_active_i | input | 1 | Package-active indication that permits automatic entry |
| wake_i | input | 1 | Wake request |
| prech_done_i | input | 1 | Precharge-all done and CKE low on all ranks |
| prech_req_o | output | 1 | Request to precharge all banks and drop CKE |
| sr_cmd_o | output | 1 | One-cycle self-refresh entry command strobe |
| sr_active_o | output | 1 | Channel is in self-refresh |
| core_off_ok_o | output | 1 | Controller core power may be removed |

## Verification
The assertions watch several properties on every cycle:
- the three phase outputs never overlap;
- the entry strobe lasts one cycle and always follows a completed precharge handshake;
- the request holds until done;
- the status flags agree with each other and fall in the same cycle as a wake or access;
- a precharge request only ever rises because of an external request or an enabled automatic path.

Only the bench's scenarios can show the exact entry cycle for a given threshold. They also show that an access or a loss of the drained state in mid-count restarts the count, and that disabling the automatic path, or dropping the package-active indication, keeps the channel awake for a long idle stretch.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PRECH = 2'd1,
    PH_ENTER = 2'd2,
    PH_SR    = 2'd3
  } sr_phase_e;

endpackage

// File: rtl/sr_idle_cnt.sv
module sr_idle_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = (cnt_q >= limit_i);

  // Cleared whenever the channel is not idle; saturates at the threshold.
  always_ff @(posedge clk) begin
    if (rst || !idle_i) begin
      cnt_q <= '0;
    end else if (!at_limit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit_o = idle_i && at_limit;

endmodule

// File: rtl/sr_entry_fsm.sv
module sr_entry_fsm
  import sr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_i,
  input  logic      prech_done_i,
  input  logic      exit_i,
  output sr_phase_e phase_o
);

  sr_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (start_i)      phase_d = PH_PRECH;
      PH_PRECH: if (prech_done_i) phase_d = PH_ENTER;
      PH_ENTER:                   phase_d = PH_SR;
      PH_SR:    if (exit_i)       phase_d = PH_IDLE;
      default:                    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/sr_entry_ctrl.sv
module sr_entry_ctrl
  import sr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             access_i,
  input  logic             drained_i,
  input  logic             auto_en_i,
  input  logic [CNT_W-1:0] idle_limit_i,
  input  logic             ext_req_i,
  input  logic             pkg_active_i,
  input  logic             wake_i,
  input  logic             prech_done_i,
  output logic             prech_req_o,
  output logic             sr_cmd_o,
  output logic             sr_active_o,
  output logic             core_off_ok_o
);

  sr_phase_e phase;
  logic      idle_cond;
  logic      cnt_hit;
  logic      auto_go;
  logic      exit_req;

  assign idle_cond = (phase == PH_IDLE) && drained_i && !access_i;

  sr_idle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .idle_i  (idle_cond),
    .limit_i (idle_limit_i),
    .hit_o   (cnt_hit)
  );

  assign auto_go  = cnt_hit && auto_en_i && pkg_active_i;
  assign exit_req = wake_i || access_i;

  sr_entry_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start_i      (ext_req_i || auto_go),
    .prech_done_i (prech_done_i),
    .exit_i       (exit_req),
    .phase_o      (phase)
  );

  assign prech_req_o   = (phase == PH_PRECH);
  assign sr_cmd_o      = (phase == PH_ENTER);
  assign sr_active_o   = (phase == PH_SR) && !exit_req;
  assign core_off_ok_o = (phase == PH_SR) && !exit_req;

endmodule

// File: rtl/sr_entry_ctrl_chk.sv
module sr_entry_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic access_i,
  input logic auto_en_i,
  input logic ext_req_i,
  input logic pkg_active_i,
  input logic wake_i,
  input logic prech_done_i,
  input logic prech_req_o,
  input logic sr_cmd_o,
  input logic sr_active_o,
  input logic core_off_ok_o
);

  // R11
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prech_req_o, sr_cmd_o, sr_active_o}));

  // R8
  cmd_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    sr_cmd_o |-> $past(prech_req_o && prech_done_i));

  // R8
  cmd_single_chk: assert property (@(posedge clk) disable iff (rst)
    sr_cmd_o |=> !sr_cmd_o);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (prech_req_o && !prech_done_i) |=> prech_req_o);

  // R9
  enter_sr_chk: assert property (@(posedge clk) disable iff (rst)
    sr_cmd_o |=> (sr_active_o || wake_i || access_i));

  // R9
  flags_agree_chk: assert property (@(posedge clk) disable iff (rst)
    sr_active_o == core_off_ok_o);

  // R10
  wake_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_i || access_i) |-> (!sr_active_o && !core_off_ok_o));

  // R5
  // R6
  // R7
  start_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(prech_req_o) |-> $past(ext_req_i || (auto_en_i && pkg_active_i)));

endmodule

bind sr_entry_ctrl sr_entry_ctrl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .access_i      (access_i),
  .auto_en_i     (auto_en_i),
  .ext_req_i     (ext_req_i),
  .pkg_active_i  (pkg_active_i),
  .wake_i        (wake_i),
  .prech_done_i  (prech_done_i),
  .prech_req_o   (prech_req_o),
  .sr_cmd_o      (sr_cmd_o),
  .sr_active_o   (sr_active_o),
  .core_off_ok_o (core_off_ok_o)
);

// File: tb/test_sr_entry_ctrl.sv
`timescale 1ns/1ps
module test_sr_entry_ctrl;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             access_i = 1'b0;
  logic             drained_i = 1'b0;
  logic             auto_en_i = 1'b0;
  logic [CNT_W-1:0] idle_limit_i = '0;
  logic             ext_req_i = 1'b0;
  logic             pkg_active_i = 1'b0;
  logic             wake_i = 1'b0;
  logic             prech_done_i = 1'b0;
  logic             prech_req_o, sr_cmd_o, sr_active_o, core_off_ok_o;

  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  int resp_wait = 0;
  int pw = 0;
  int exp_q[$];
  int d;

  always #10 clk = ~clk;

  sr_entry_ctrl #(.CNT_W(CNT_W)) i_sr_entry_ctrl (
    .clk(clk), .rst(rst), .access_i(access_i), .drained_i(drained_i),
    .auto_en_i(auto_en_i), .idle_limit_i(idle_limit_i), .ext_req_i(ext_req_i),
    .pkg_active_i(pkg_active_i), .wake_i(wake_i), .prech_done_i(prech_done_i),
    .prech_req_o(prech_req_o), .sr_cmd_o(sr_cmd_o), .sr_active_o(sr_active_o),
    .core_off_ok_o(core_off_ok_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Precharge responder: done after resp_wait cycles of request.
  always @(posedge clk) begin
    #1;
    if (prech_req_o) begin
      prech_done_i = (pw >= resp_wait);
      pw++;
    end else begin
      prech_done_i = 1'b0;
      pw = 0;
    end
  end

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog: actual cycle %0d expected < 20000", cyc);
      summary_and_end();
    end
  end

  // Monitor: each entry strobe is compared with the next expected cycle.
  always @(negedge clk) begin
    if (!rst && sr_cmd_o) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R8 unexpected sr_cmd_o at cycle %0d: actual 1 expected 0", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          mismatched++;
          $display("FAIL R4 entry cycle: actual %0d expected %0d", cyc, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %0b expected %0b", req, cyc, act, exp);
    end
  endtask

  task automatic check_at_neg(input string req, input logic [3:0] exp);
    @(negedge clk);
    check({req, " prech_req"}, prech_req_o, exp[3]);
    check({req, " sr_cmd"}, sr_cmd_o, exp[2]);
    check({req, " sr_active"}, sr_active_o, exp[1]);
    check({req, " core_off_ok"}, core_off_ok_o, exp[0]);
    tick(1);
  endtask

  initial begin
    // R1 reset state
    tick(3);
    check_at_neg("R1 in reset", 4'b0000);
    rst = 1'b0;
    check_at_neg("R1 after reset", 4'b0000);

    // R3 R4 automatic entry with limit 5
    idle_limit_i = 16'd5; auto_en_i = 1'b1; pkg_active_i = 1'b1; drained_i = 1'b1;
    exp_q.push_back(cyc + 2 + 5);
    tick(10);
    check_at_neg("R9 in self-refresh", 4'b0011);

    // R10 wake clears flags in the same cycle, count restarts
    wake_i = 1'b1; d = cyc;
    exp_q.push_back(d + 3 + 5);
    @(negedge clk);
    check("R10 wake sr_active", sr_active_o, 1'b0);
    check("R10 wake core_off_ok", core_off_ok_o, 1'b0);
    tick(1);
    wake_i = 1'b0;
    tick(10);
    check_at_neg("R10 re-entry", 4'b0011);

    // R10 access also exits; stay out by dropping drained (R3)
    access_i = 1'b1; drained_i = 1'b0;
    @(negedge clk);
    check("R10 access sr_active", sr_active_o, 1'b0);
    tick(1);
    access_i = 1'b0;
    tick(20);
    check_at_neg("R3 not drained holds count", 4'b0000);

    // R2 access mid-count restarts the count
    idle_limit_i = 16'd8; drained_i = 1'b1;
    tick(4);
    access_i = 1'b1; d = cyc;
    tick(1);
    access_i = 1'b0;
    exp_q.push_back(d + 3 + 8);
    tick(6);
    check("R2 no early entry", prech_req_o | sr_active_o, 1'b0);
    tick(10);
    check_at_neg("R2 entered after restart", 4'b0011);

    // R3 drained drop mid-count restarts the count
    wake_i = 1'b1; drained_i = 1'b0;
    tick(1);
    wake_i = 1'b0; drained_i = 1'b1;
    tick(4);
    drained_i = 1'b0; d = cyc;
    tick(1);
    drained_i = 1'b1;
    exp_q.push_back(d + 3 + 8);
    tick(15);
    check_at_neg("R3 entered after drained restart", 4'b0011);

    // R5 auto disabled
    wake_i = 1'b1; auto_en_i = 1'b0;
    tick(1);
    wake_i = 1'b0;
    tick(40);
    check_at_neg("R5 auto disabled", 4'b0000);

    // R6 package inactive
    idle_limit_i = 16'd2; auto_en_i = 1'b1; pkg_active_i = 1'b0;
    tick(40);
    check_at_neg("R6 package inactive", 4'b0000);

    // R7 external request overrides disabled auto path
    ext_req_i = 1'b1; d = cyc;
    exp_q.push_back(d + 2);
    tick(1);
    ext_req_i = 1'b0;
    tick(4);
    check_at_neg("R7 external entry", 4'b0011);

    // R8 precharge handshake with a slow done
    wake_i = 1'b1;
    tick(1);
    wake_i = 1'b0;
    tick(3);
    resp_wait = 3; auto_en_i = 1'b0;
    ext_req_i = 1'b1; d = cyc;
    exp_q.push_back(d + 2 + 3);
    tick(1);
    ext_req_i = 1'b0;
    tick(2);
    check_at_neg("R8 waiting for done", 4'b1000);
    tick(5);
    check_at_neg("R8 entered after done", 4'b0011);

    // R4 limit zero: entry on the first idle cycle after wake
    resp_wait = 0; idle_limit_i = 16'd0; auto_en_i = 1'b1; pkg_active_i = 1'b1;
    wake_i = 1'b1; d = cyc;
    exp_q.push_back(d + 3);
    tick(1);
    wake_i = 1'b0;
    tick(5);
    check_at_neg("R4 limit zero", 4'b0011);

    tick(3);
    compared++;
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R8 missing entries: actual %0d left expected 0", exp_q.size());
    end
    summary_and_end();
  end

endmodule